// File: doc/BRIEF.md
# Decimal Operand Alignment Calculator

This block lines up two unnormalized decimal significands, each stored as packed BCD digits with its own exponent, so that a later adder can work on them digit for digit. Since decimal values are not normalized, the operand with the larger exponent often has leading zero digits. The block uses those zeros first: it shifts that operand left, which reduces its exponent, and it right-shifts the other operand only by the exponent gap that still remains. This keeps as many digits of the smaller operand as possible.

The block counts the leading zero digits of the larger-exponent operand itself. It returns the left-aligned larger operand and the right-aligned smaller operand. The smaller operand is widened by a guard digit and a round digit, and a sticky bit holds every digit that drops off below the round digit. The block also returns the common exponent of the aligned pair, a flag that shows whether the inputs were swapped, and a flag that shows the two exponents were equal. The result is captured in one register stage, which is loaded when `in_valid` is high. The stage has no state machine; it is a single clocked register.

Top module: `dec_align`

## Requirements
- R1: When `exp_a` < `exp_b`, `swapped` is 1 and the B operand becomes the larger-exponent operand. Otherwise `swapped` is 0 and A takes that role. Equal exponents never swap.
- R2: Let d be the absolute exponent difference and z the count of leading zero digits of the larger operand. When z >= d, the larger operand is shifted left by d digits. The smaller operand then appears unshifted in the upper 16 digits of `small_sig`, guard and round are zero, and `small_sticky` is 0.
- R3: When z < d, the larger operand is shifted left by z digits and the smaller operand is shifted right by d - z digits.
- R4: The right-shift amount is limited to 19 digits. With a shift of 18 or more, `small_sig` is all zero and `small_sticky` equals the OR of all bits of the smaller significand.
- R5: `small_sig` holds 18 digits: bits [71:8] are the 16 significand digits, bits [7:4] are the guard digit and bits [3:0] are the round digit. `small_sticky` is the OR of every digit shifted below the round digit.
- R6: `res_exp` equals the larger exponent minus the left-shift amount that was applied.
- R7: `same_q` is 1 exactly when `exp_a` equals `exp_b`.
- R8: Outputs update on the clock edge where `in_valid` is 1, and `out_valid` is 1 in the following cycle. When `in_valid` is 0, `out_valid` drops to 0 and the data outputs keep their last values.
- R9: After reset, `out_valid` is 0 and all data outputs are zero.
- R10: An all-zero significand counts 16 leading zeros, so as the larger operand it can absorb a gap of up to 16 by left shift alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load the operands this cycle |
| sig_a | input | 64 | Operand A significand, 16 BCD digits |
| exp_a | input | 10 | Operand A exponent, unsigned |
| sig_b | input | 64 | Operand B significand, 16 BCD digits |
| exp_b | input | 10 | Operand B exponent, unsigned |
| out_valid | output | 1 | Aligned result present |
| big_sig | output | 64 | Left-aligned larger-exponent significand |
| small_sig | output | 72 | Right-aligned smaller significand with guard and round digits |
| small_sticky | output | 1 | OR of digits shifted beyond the round digit |
| res_exp | output | 10 | Common exponent of the aligned pair |
| swapped | output | 1 | Operands were exchanged |
| same_q | output | 1 | Input exponents were equal |

## Verification
The bench builds the block with its default values: 16 digits, 10-bit exponents and a right-shift limit of 19. With 10-bit exponents, gaps of several hundred are possible, so the limit of 19 is crossed easily. Small gaps around the leading-zero count still cover the boundary between the left-only case and the split case. Random operands with a random number of leading zero digits, along with all-zero operands, exercise every left-shift amount from 0 to 16 and every right-shift amount up to the limit.

// File: rtl/dec_align_pkg.sv
package dec_align_pkg;
    localparam int unsigned DEF_DIGITS = 16;
    localparam int unsigned DEF_EXPW   = 10;
    localparam int unsigned DEF_RCAP   = 19;
    localparam int unsigned EXTRA_DIG  = 2;   // guard and round
    localparam int unsigned DIGW       = 4;

    typedef logic [DIGW-1:0] bcd_digit_t;
endpackage

// File: rtl/dec_lzc.sv
module dec_lzc
    import dec_align_pkg::*;
#(
    parameter int unsigned NDIG = DEF_DIGITS,
    localparam int unsigned CW  = $clog2(NDIG + 1)
) (
    input  logic [DIGW*NDIG-1:0] sig,
    output logic [CW-1:0]        zcount
);
    logic found;

    always_comb begin
        zcount = CW'(NDIG);
        found  = 1'b0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            if (!found && (sig[DIGW*i +: DIGW] != '0)) begin
                zcount = CW'(NDIG - 1 - i);
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        a_r10_count_range: assert (zcount <= CW'(NDIG));
    end
endmodule

// File: rtl/dec_lshift.sv
module dec_lshift
    import dec_align_pkg::*;
#(
    parameter int unsigned NDIG = DEF_DIGITS,
    localparam int unsigned CW  = $clog2(NDIG + 1)
) (
    input  logic [DIGW*NDIG-1:0] din,
    input  logic [CW-1:0]        amt,
    output logic [DIGW*NDIG-1:0] dout
);
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        always_comb begin
            dout[DIGW*g +: DIGW] = '0;
            for (int s = 0; s <= g; s++) begin
                if (amt == CW'(s))
                    dout[DIGW*g +: DIGW] = din[DIGW*(g-s) +: DIGW];
            end
        end
    end
endmodule

// File: rtl/dec_rshift.sv
module dec_rshift
    import dec_align_pkg::*;
#(
    parameter int unsigned NDIG = DEF_DIGITS,
    parameter int unsigned RCAP = DEF_RCAP,
    localparam int unsigned SW  = $clog2(RCAP + 1),
    localparam int unsigned XD  = NDIG + EXTRA_DIG
) (
    input  logic [DIGW*NDIG-1:0] din,
    input  logic [SW-1:0]        amt,
    output logic [DIGW*XD-1:0]   dout,
    output logic                 sticky
);
    logic [DIGW*XD-1:0] ext;
    logic [XD-1:0]      dropped;

    assign ext = {din, {(DIGW*EXTRA_DIG){1'b0}}};

    for (genvar g = 0; g < XD; g++) begin : g_dig
        always_comb begin
            dout[DIGW*g +: DIGW] = '0;
            for (int s = 0; s <= RCAP; s++) begin
                if ((amt == SW'(s)) && (g + s < XD))
                    dout[DIGW*g +: DIGW] = ext[DIGW*(g+s) +: DIGW];
            end
        end
        assign dropped[g] = (32'(g) < 32'(amt)) && (ext[DIGW*g +: DIGW] != '0);
    end

    assign sticky = |dropped;

    always_comb begin
        if (amt == '0) begin
            a_r5_no_drop_without_shift: assert (!sticky);
        end
    end
endmodule

// File: rtl/dec_align.sv
module dec_align
    import dec_align_pkg::*;
#(
    parameter int unsigned NDIG = DEF_DIGITS,
    parameter int unsigned EW   = DEF_EXPW,
    parameter int unsigned RCAP = DEF_RCAP,
    localparam int unsigned CW  = $clog2(NDIG + 1),
    localparam int unsigned SW  = $clog2(RCAP + 1),
    localparam int unsigned W   = DIGW * NDIG,
    localparam int unsigned WX  = DIGW * (NDIG + EXTRA_DIG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  sig_a,
    input  logic [EW-1:0] exp_a,
    input  logic [W-1:0]  sig_b,
    input  logic [EW-1:0] exp_b,
    output logic          out_valid,
    output logic [W-1:0]  big_sig,
    output logic [WX-1:0] small_sig,
    output logic          small_sticky,
    output logic [EW-1:0] res_exp,
    output logic          swapped,
    output logic          same_q
);
    logic          swap_c;
    logic [W-1:0]  big_in, small_in;
    logic [EW-1:0] big_exp, diff;
    logic [CW-1:0] zcnt, lsh;
    logic [EW-1:0] rem;
    logic [SW-1:0] rsh;
    logic [W-1:0]  big_al;
    logic [WX-1:0] small_al;
    logic          sticky_c;

    // operand ordering
    always_comb begin
        swap_c   = exp_a < exp_b;
        big_in   = swap_c ? sig_b : sig_a;
        small_in = swap_c ? sig_a : sig_b;
        big_exp  = swap_c ? exp_b : exp_a;
        diff     = swap_c ? (exp_b - exp_a) : (exp_a - exp_b);
    end

    dec_lzc #(.NDIG(NDIG)) u_lzc (
        .sig    (big_in),
        .zcount (zcnt)
    );

    // split of the gap into left and right parts
    always_comb begin
        if (EW'(zcnt) < diff) begin
            lsh = zcnt;
            rem = diff - EW'(zcnt);
            rsh = (rem > EW'(RCAP)) ? SW'(RCAP) : SW'(rem);
        end else begin
            lsh = CW'(diff);
            rem = '0;
            rsh = '0;
        end
    end

    dec_lshift #(.NDIG(NDIG)) u_lsh (
        .din  (big_in),
        .amt  (lsh),
        .dout (big_al)
    );

    dec_rshift #(.NDIG(NDIG), .RCAP(RCAP)) u_rsh (
        .din    (small_in),
        .amt    (rsh),
        .dout   (small_al),
        .sticky (sticky_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            big_sig      <= '0;
            small_sig    <= '0;
            small_sticky <= 1'b0;
            res_exp      <= '0;
            swapped      <= 1'b0;
            same_q       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                big_sig      <= big_al;
                small_sig    <= small_al;
                small_sticky <= sticky_c;
                res_exp      <= big_exp - EW'(lsh);
                swapped      <= swap_c;
                same_q       <= (exp_a == exp_b);
            end
        end
    end

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_swap_on_smaller_a: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (exp_a < exp_b)) |=> swapped);
    a_r7_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && same_q) |-> (!swapped && !small_sticky && small_sig[7:0] == 8'h00));
    a_r6_exp_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_exp <= (($past(exp_a) > $past(exp_b)) ? $past(exp_a) : $past(exp_b))));
endmodule

// File: tb/dec_align_tb.sv
module dec_align_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] sig_a = '0, sig_b = '0;
    logic [9:0]  exp_a = '0, exp_b = '0;
    logic        out_valid, small_sticky, swapped, same_q;
    logic [63:0] big_sig;
    logic [71:0] small_sig;
    logic [9:0]  res_exp;

    int total = 0;
    int bad = 0;

    // reference model state (what the outputs should hold)
    logic        m_valid = 0, m_sticky = 0, m_swap = 0, m_same = 0;
    logic [63:0] m_big = '0;
    logic [71:0] m_small = '0;
    logic [9:0]  m_exp = '0;

    always #5 clk = ~clk;

    dec_align u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .sig_a(sig_a), .exp_a(exp_a), .sig_b(sig_b), .exp_b(exp_b),
        .out_valid(out_valid), .big_sig(big_sig), .small_sig(small_sig),
        .small_sticky(small_sticky), .res_exp(res_exp),
        .swapped(swapped), .same_q(same_q)
    );

    task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lead_zeros(logic [63:0] s);
        for (int i = 15; i >= 0; i--)
            if (s[4*i +: 4] != 4'd0) return 15 - i;
        return 16;
    endfunction

    task automatic model(logic [63:0] a, int ea, logic [63:0] b, int eb);
        logic [63:0] bg, sm;
        logic [71:0] ext;
        int big_e, d, z, l, r;
        m_swap = ea < eb;
        bg = m_swap ? b : a;
        sm = m_swap ? a : b;
        big_e = m_swap ? eb : ea;
        d = m_swap ? eb - ea : ea - eb;
        z = lead_zeros(bg);
        if (z >= d) begin l = d; r = 0; end
        else begin l = z; r = d - z; if (r > 19) r = 19; end
        m_big = bg << (4 * l);
        ext = {sm, 8'h00};
        m_sticky = 1'b0;
        for (int k = 0; k < 18; k++)
            if (k < r && ext[4*k +: 4] != 4'd0) m_sticky = 1'b1;
        m_small = (r >= 18) ? 72'd0 : (ext >> (4 * r));
        m_exp = 10'(big_e - l);
        m_same = (ea == eb);
    endtask

    task automatic compare_all();
        chk("R8 out_valid", 72'(out_valid), 72'(m_valid));
        chk("R1/R2/R3 big_sig", 72'(big_sig), 72'(m_big));
        chk("R3/R4 small_sig", small_sig, m_small);
        chk("R4/R5 sticky", 72'(small_sticky), 72'(m_sticky));
        chk("R6/R10 res_exp", 72'(res_exp), 72'(m_exp));
        chk("R1 swapped", 72'(swapped), 72'(m_swap));
        chk("R7 same_q", 72'(same_q), 72'(m_same));
    endtask

    // one cycle: check current outputs, then drive next inputs
    task automatic step(logic v, logic [63:0] a, int ea, logic [63:0] b, int eb);
        @(negedge clk);
        compare_all();
        in_valid = v; sig_a = a; exp_a = 10'(ea); sig_b = b; exp_b = 10'(eb);
        m_valid = v;
        if (v) model(a, ea, b, eb);
    endtask

    function automatic logic [63:0] rand_sig(int nz);
        logic [63:0] s = '0;
        for (int i = 0; i < 16 - nz; i++) s[4*i +: 4] = 4'($urandom % 10);
        if (nz < 16 && s[4*(15-nz) +: 4] == 4'd0) s[4*(15-nz) +: 4] = 4'd7;
        return s;
    endfunction

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all(); // R9 reset state
        chk("R9 reset out_valid", 72'(out_valid), 72'd0);
        rst_n = 1'b1;
        // worked case: 5 leading zeros, gap 9
        step(1, 64'h0000_0123_4567_8901, 109, 64'h1234_5678_9012_3456, 100);
        // swap, gap small and absorbed (R2)
        step(1, 64'h9876_5432_1098_7654, 200, 64'h0000_0000_0000_0042, 203);
        // equal exponents (R7)
        step(1, 64'h1111_2222_3333_4444, 50, 64'h5555_6666_7777_8888, 50);
        // huge gap: cap (R4)
        step(1, 64'h9999_9999_9999_9999, 900, 64'h0000_0000_0000_0001, 10);
        // zero larger operand, gap 16 then 40 (R10)
        step(1, 64'h0, 316, 64'h1234_5678_9012_3456, 300);
        step(1, 64'h0, 340, 64'h1234_5678_9012_3456, 300);
        // idle hold (R8)
        step(0, 64'h1, 1, 64'h2, 2);
        step(0, 64'h3, 3, 64'h4, 4);
        // guard/round only, no sticky: gap exceeds zeros by 2
        step(1, 64'h0001_2345_6789_0123, 30, 64'h4321_4321_4321_4321, 25);
        for (int n = 0; n < 600; n++) begin
            int ea, eb;
            ea = 20 + int'($urandom % 900);
            case ($urandom % 3)
                0: eb = ea;
                1: eb = ea + int'($urandom % 41) - 20;
                default: eb = int'($urandom % 1024);
            endcase
            if (eb < 0) eb = 0;
            if (eb > 1023) eb = 1023;
            step(($urandom % 5) != 0, rand_sig(int'($urandom % 17)), ea,
                 rand_sig(int'($urandom % 17)), eb);
        end
        step(0, 64'h0, 0, 64'h0, 0);
        step(0, 64'h0, 0, 64'h0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule